// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block collects interrupt requests for a host bus controller and folds them into one level interrupt output. Up to seventeen serial interrupt request lines and a small group of bus error events set bits in a first-level status word. A request line sets its bit only on a low-to-high transition. An error event sets its bit in every cycle it is high. Software chooses which bits may contribute through a mask, and a global enable in a control word gates the masked result. The gated result is a single intermediate signal that appears in a read-only second-level input word at bit 11.

The second level is a sticky latch. In every cycle, the input word ANDed with a second-level mask is ORed into a second-level status word. The output `irq_out` is high while that status word is nonzero. Both status words are write-one-to-clear, so software acknowledges an interrupt at the first level and then at the second. Two further words hold firmware window settings and a polarity value. They are plain storage with no effect on interrupt behaviour.

All registers are 32 bits wide, with bit 31 as the most significant bit, on a simple word bus. A write is taken when `reg_wr` is high at a rising clock edge. Read data is a combinational function of `reg_addr`, and a read has no side effects. The bus has no handshake and no back-pressure: every write completes in the cycle it is presented.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every register reads zero except the firmware access-size word at offset 0x28, which reads 0x02000000. `irq_out` is low.
- R2: A rising edge on `req_lines[n]` sets first-level status bit 31-n at offset 0x38. The bit stays set while the line stays high and after it falls. A line held high after its bit is cleared does not set the bit again until it next rises.
- R3: While `err_evt[k]` is high, first-level status bit 2+k is set.
- R4: A write to offset 0x38 clears exactly the status bits where the written value has a one. All other bits are left unchanged.
- R5: Bit 11 of the read-only input word at 0x5C is high only when bit 31 of the control word at 0x30 is set and the AND of the status word at 0x38 with the mask word at 0x34 is nonzero. All other bits of 0x5C read zero.
- R6: In each cycle, the second-level status word at 0x50 takes on the bits of (input word AND mask word at 0x54). A set bit stays set until software writes a one to that bit at 0x50.
- R7: `irq_out` is high exactly while the second-level status word is nonzero.
- R8: When a set and a software clear reach the same status bit in the same cycle, at either level, the bit ends up set.
- R9: Any offset other than 0x24, 0x28, 0x30, 0x34, 0x38, 0x40, 0x50, 0x54, 0x58 and 0x5C reads 0xFFFFFFFF. Writes to 0x40 (error address, reads zero) and to 0x5C have no effect.
- R10: The polarity word at 0x58 reads back its last written value and has no effect on `irq_out`.
- R11: The words at 0x24, 0x28, 0x30, 0x34 and 0x54 read back their last written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_lines | input | 17 | Decoded serial interrupt request levels |
| err_evt | input | 6 | Bus error event flags, set status bits 7..2 |
| reg_wr | input | 1 | Write strobe for the register word bus |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Level interrupt to the downstream controller |

## Verification
Two things can hit the same status bit in the same clock: a hardware set, and a software write-one-to-clear. At the first level the set is a request line rising. At the second level it is a held input that passes the mask. The bench provokes the first case by raising a request line on the same edge as a clear write to that line's bit. It provokes the second case by clearing the second-level bit while the first-level output is still active. In both cases the status is read back on the following cycle and must show the bit still set. The bench also sweeps every request line, with the enable on and off and with the mask matched and mismatched, and computes each expected bit arithmetically.

// File: rtl/aggr_pkg.sv
package aggr_pkg;
  localparam int DW = 32;
  localparam int AW = 8;

  typedef logic [DW-1:0] word_t;
  typedef logic [AW-1:0] addr_t;

  // first-level register offsets
  localparam addr_t OFS_FWSEG   = 8'h24;
  localparam addr_t OFS_FWSIZE  = 8'h28;
  localparam addr_t OFS_HCTL    = 8'h30;
  localparam addr_t OFS_HMASK   = 8'h34;
  localparam addr_t OFS_HSTAT   = 8'h38;
  localparam addr_t OFS_ERRADDR = 8'h40;
  // second-level register offsets
  localparam addr_t OFS_MSTAT   = 8'h50;
  localparam addr_t OFS_MMASK   = 8'h54;
  localparam addr_t OFS_MPOL    = 8'h58;
  localparam addr_t OFS_MIN     = 8'h5C;

  localparam word_t FWSIZE_RST = 32'h0200_0000;
  localparam word_t ALL_ONES   = '1;
endpackage

// File: rtl/req_latch.sv
module req_latch
  import aggr_pkg::*;
#(
  parameter int NUM_REQ = 17,
  parameter int NUM_ERR = 6,
  parameter int ERR_LSB = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req,
  input  logic [NUM_ERR-1:0] err,
  input  logic               clr_en,
  input  word_t              clr_bits,
  output word_t              stat
);
  localparam int REQ_LSB = DW - NUM_REQ;
  localparam int ERR_MSB = ERR_LSB + NUM_ERR - 1;

  logic [NUM_REQ-1:0] req_q;
  word_t set_vec;
  word_t clr_vec;
  word_t stat_d;

  // previous request levels for edge detection
  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req;
  end

  // per-bit source of a set: request rise, error level, or none
  for (genvar b = 0; b < DW; b++) begin : g_set
    if (b >= REQ_LSB) begin : g_req
      assign set_vec[b] = req[DW-1-b] & ~req_q[DW-1-b];
    end else if (b >= ERR_LSB && b <= ERR_MSB) begin : g_err
      assign set_vec[b] = err[b-ERR_LSB];
    end else begin : g_none
      assign set_vec[b] = 1'b0;
    end
  end

  assign clr_vec = clr_en ? clr_bits : '0;
  // a set in the same cycle overrides the clear
  assign stat_d  = (stat & ~clr_vec) | set_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= stat_d;
  end

  // R2
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((stat & $past(stat)) == $past(stat)));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((stat & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/host_regs.sv
module host_regs
  import aggr_pkg::*;
#(
  parameter int EN_BIT = 31
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  addr_t addr,
  input  word_t wdata,
  input  word_t stat,
  output word_t ctl,
  output word_t mask,
  output word_t fwseg,
  output word_t fwsize,
  output logic  host_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl    <= '0;
      mask   <= '0;
      fwseg  <= '0;
      fwsize <= FWSIZE_RST;
    end else if (wr) begin
      case (addr)
        OFS_HCTL:   ctl    <= wdata;
        OFS_HMASK:  mask   <= wdata;
        OFS_FWSEG:  fwseg  <= wdata;
        OFS_FWSIZE: fwsize <= wdata;
        default: ;
      endcase
    end
  end

  assign host_out = ctl[EN_BIT] && ((stat & mask) != '0);

  // R5
  host_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_HCTL && !wdata[EN_BIT]) |=> !host_out);
endmodule

// File: rtl/master_latch.sv
module master_latch
  import aggr_pkg::*;
#(
  parameter int IN_BIT = 11
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  host_in,
  input  logic  wr,
  input  addr_t addr,
  input  word_t wdata,
  output word_t mst_stat,
  output word_t mst_mask,
  output word_t mst_pol,
  output word_t mst_in,
  output logic  irq
);
  logic  clr_en;
  word_t stat_d;

  assign mst_in = word_t'(host_in) << IN_BIT;
  assign clr_en = wr && (addr == OFS_MSTAT);
  assign stat_d = (mst_stat & ~(clr_en ? wdata : '0)) | (mst_in & mst_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mst_stat <= '0;
      mst_mask <= '0;
      mst_pol  <= '0;
    end else begin
      mst_stat <= stat_d;
      if (wr && addr == OFS_MMASK) mst_mask <= wdata;
      if (wr && addr == OFS_MPOL)  mst_pol  <= wdata;
    end
  end

  assign irq = (mst_stat != '0);

  // R6
  latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_in && mst_mask[IN_BIT]) |=> mst_stat[IN_BIT]);

  // R7
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(clr_en));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import aggr_pkg::*;
#(
  parameter int NUM_REQ = 17,
  parameter int NUM_ERR = 6,
  parameter int ERR_LSB = 2,
  parameter int EN_BIT  = 31,
  parameter int IN_BIT  = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_lines,
  input  logic [NUM_ERR-1:0] err_evt,
  input  logic               reg_wr,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  output logic               irq_out
);
  word_t h_stat, h_ctl, h_mask, h_fwseg, h_fwsize;
  word_t m_stat, m_mask, m_pol, m_in;
  logic  h_out;
  logic  h_clr;

  assign h_clr = reg_wr && (reg_addr == OFS_HSTAT);

  req_latch #(.NUM_REQ(NUM_REQ), .NUM_ERR(NUM_ERR), .ERR_LSB(ERR_LSB)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req_lines),
    .err      (err_evt),
    .clr_en   (h_clr),
    .clr_bits (reg_wdata),
    .stat     (h_stat)
  );

  host_regs #(.EN_BIT(EN_BIT)) u_host (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .stat     (h_stat),
    .ctl      (h_ctl),
    .mask     (h_mask),
    .fwseg    (h_fwseg),
    .fwsize   (h_fwsize),
    .host_out (h_out)
  );

  master_latch #(.IN_BIT(IN_BIT)) u_mst (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_in  (h_out),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .mst_stat (m_stat),
    .mst_mask (m_mask),
    .mst_pol  (m_pol),
    .mst_in   (m_in),
    .irq      (irq_out)
  );

  always_comb begin
    case (reg_addr)
      OFS_FWSEG:   reg_rdata = h_fwseg;
      OFS_FWSIZE:  reg_rdata = h_fwsize;
      OFS_HCTL:    reg_rdata = h_ctl;
      OFS_HMASK:   reg_rdata = h_mask;
      OFS_HSTAT:   reg_rdata = h_stat;
      OFS_ERRADDR: reg_rdata = '0;
      OFS_MSTAT:   reg_rdata = m_stat;
      OFS_MMASK:   reg_rdata = m_mask;
      OFS_MPOL:    reg_rdata = m_pol;
      OFS_MIN:     reg_rdata = m_in;
      default:     reg_rdata = ALL_ONES;
    endcase
  end

  // R8
  clear_then_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_MSTAT && h_out && m_mask[IN_BIT]) |=> irq_out);
endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] req_lines = '0;
  logic [5:0]  err_evt = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] rv;

  always #10 clk = ~clk; // 50 MHz

  irq_aggregator dut (
    .clk(clk), .rst_n(rst_n), .req_lines(req_lines), .err_evt(err_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_req(input int n);
    @(negedge clk); req_lines[n] = 1'b1;
    @(negedge clk); req_lines[n] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] offs [6];
    logic [7:0] bad  [8];
    offs = '{8'h24, 8'h28, 8'h30, 8'h34, 8'h54, 8'h58};
    bad  = '{8'h00, 8'h20, 8'h2C, 8'h3C, 8'h44, 8'h4C, 8'h60, 8'hFC};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(8'h24, rv); chk("R1 fwseg", rv, 32'h0);
    rd(8'h28, rv); chk("R1 fwsize", rv, 32'h0200_0000);
    rd(8'h30, rv); chk("R1 ctl", rv, 32'h0);
    rd(8'h34, rv); chk("R1 hmask", rv, 32'h0);
    rd(8'h38, rv); chk("R1 hstat", rv, 32'h0);
    rd(8'h40, rv); chk("R1 erraddr", rv, 32'h0);
    rd(8'h50, rv); chk("R1 mstat", rv, 32'h0);
    rd(8'h54, rv); chk("R1 mmask", rv, 32'h0);
    rd(8'h58, rv); chk("R1 mpol", rv, 32'h0);
    rd(8'h5C, rv); chk("R1 min", rv, 32'h0);
    chk("R1 irq_out", {31'b0, irq_out}, 32'h0);

    // R11 storage words, R10 polarity readback
    foreach (offs[i]) begin
      wr(offs[i], 32'hA5C3_0000 | {24'b0, offs[i]});
      rd(offs[i], rv);
      chk(offs[i] == 8'h58 ? "R10 pol readback" : "R11 readback", rv, 32'hA5C3_0000 | {24'b0, offs[i]});
    end
    wr(8'h30, 0); wr(8'h34, 0); wr(8'h54, 0); wr(8'h58, 0);

    // R2 every request line sets bit 31-n
    for (int n = 0; n < 17; n++) begin
      wr(8'h38, 32'hFFFF_FFFF);
      pulse_req(n);
      rd(8'h38, rv); chk("R2 line set", rv, 32'h1 << (31 - n));
    end
    // R2 held line does not re-set after clear
    wr(8'h38, 32'hFFFF_FFFF);
    @(negedge clk); req_lines[3] = 1'b1;
    repeat (2) @(negedge clk);
    rd(8'h38, rv); chk("R2 held set", rv, 32'h1 << 28);
    wr(8'h38, 32'h1 << 28);
    @(negedge clk);
    rd(8'h38, rv); chk("R2 held no reset", rv, 32'h0);
    req_lines[3] = 1'b0;
    repeat (2) @(negedge clk);
    rd(8'h38, rv); chk("R2 fall no set", rv, 32'h0);

    // R3 error events
    for (int k = 0; k < 6; k++) begin
      wr(8'h38, 32'hFFFF_FFFF);
      @(negedge clk); err_evt[k] = 1'b1;
      @(negedge clk); err_evt[k] = 1'b0;
      rd(8'h38, rv); chk("R3 err set", rv, 32'h1 << (2 + k));
    end

    // R4 selective clear
    wr(8'h38, 32'hFFFF_FFFF);
    pulse_req(0); pulse_req(5); pulse_req(16);
    wr(8'h38, 32'h1 << 26);
    rd(8'h38, rv); chk("R4 partial clear", rv, (32'h1 << 31) | (32'h1 << 15));

    // R5 enable and mask sweep
    for (int en = 0; en < 2; en++) begin
      for (int n = 0; n < 17; n++) begin
        for (int mm = 0; mm < 2; mm++) begin
          wr(8'h38, 32'hFFFF_FFFF);
          wr(8'h30, en == 1 ? 32'h8000_0000 : 32'h0);
          wr(8'h34, mm == 1 ? 32'h1 << (31 - ((n + 1) % 17)) : 32'h1 << (31 - n));
          pulse_req(n);
          rd(8'h5C, rv);
          chk("R5 gated input", rv, (en == 1 && mm == 0) ? 32'h800 : 32'h0);
        end
      end
    end
    chk("R6 mask blocks latch", {31'b0, irq_out}, 32'h0);

    // R6 / R7 sticky second level
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h30, 32'h8000_0000);
    wr(8'h34, 32'h8000_0000);
    wr(8'h54, 32'h800);
    wr(8'h50, 32'hFFFF_FFFF);
    pulse_req(0);
    @(negedge clk);
    chk("R7 irq high", {31'b0, irq_out}, 32'h1);
    rd(8'h50, rv); chk("R6 latched", rv, 32'h800);
    // R8 second level: clear while input still active
    wr(8'h50, 32'h800);
    rd(8'h50, rv); chk("R8 master set wins", rv, 32'h800);
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h5C, rv); chk("R5 input drops", rv, 32'h0);
    rd(8'h50, rv); chk("R6 sticky", rv, 32'h800);
    chk("R7 irq held", {31'b0, irq_out}, 32'h1);
    wr(8'h50, 32'h800);
    rd(8'h50, rv); chk("R6 cleared", rv, 32'h0);
    chk("R7 irq low", {31'b0, irq_out}, 32'h0);

    // R8 first level: rise and clear on the same edge
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h54, 32'h0);
    @(negedge clk);
    req_lines[7] = 1'b1;
    reg_wr = 1'b1; reg_addr = 8'h38; reg_wdata = 32'h0100_0000;
    @(negedge clk);
    reg_wr = 1'b0; req_lines[7] = 1'b0;
    rd(8'h38, rv); chk("R8 host set wins", rv, 32'h0100_0000);

    // R10 polarity has no effect
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h54, 32'h800);
    wr(8'h58, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R10 pol idle", {31'b0, irq_out}, 32'h0);
    pulse_req(0);
    @(negedge clk);
    chk("R10 pol irq", {31'b0, irq_out}, 32'h1);
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h58, rv); chk("R10 pol kept", rv, 32'hFFFF_FFFF);

    // R9 unimplemented offsets and read-only words
    foreach (bad[i]) begin
      rd(bad[i], rv); chk("R9 unmapped", rv, 32'hFFFF_FFFF);
    end
    wr(8'h40, 32'h1234_5678);
    rd(8'h40, rv); chk("R9 erraddr ro", rv, 32'h0);
    wr(8'h5C, 32'hFFFF_FFFF);
    rd(8'h5C, rv); chk("R9 input ro", rv, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule